// File: doc/BRIEF.md
# Dual-Period Watchdog Timeout Counter

This block is a watchdog down-counter whose timeout length is picked by two 4-bit selectors held in one 32-bit control word. The initial selector sets the period for the first load after the watchdog is enabled. The normal selector sets the period for every later restart (kick). Each selector value picks a power-of-two period. Any period that does not fit in the counter is clipped to the counter's full range.

Software writes the control word, raises the enable and kicks at regular intervals. If a kick does not arrive before the count runs out, a sticky timeout flag is raised. Parameters can hard-code both selectors, remove the initial selector, or keep the watchdog permanently enabled. The current count is visible at the ports for observation.

Top module: `wdog_dualperiod`

## Requirements
- R1: After reset both selectors hold 0xF, so the control word reads 0x000000FF. The count reads 0 and the timeout flag is low.
- R2: In the control word, the normal selector is in bits 3:0 and the initial selector is in bits 7:4. Bits 31:8 always read zero, and writes to them have no effect.
- R3: On the first enabled clock after the watchdog was disabled, the counter loads P-1, where P is the period picked by the initial selector. A value i picks P = 2^min(PERIOD_BASE_LOG2+i, CNT_WIDTH).
- R4: A kick while enabled loads P-1, with P picked by the normal selector, and clears the timeout flag.
- R5: While enabled and not loading, the count falls by one per clock until it reaches zero, then stays at zero. While disabled, the count holds its value.
- R6: The timeout flag rises P clocks after a load that is not followed by a kick. It then stays high until a kick or a reset.
- R7: A write to the normal selector leaves the running count unchanged. The new value is used from the next kick on.
- R8: A write to the initial selector made after the watchdog is running has no effect on the period loaded by later kicks.
- R9: A selector value whose exponent exceeds CNT_WIDTH loads all ones, for example 0xFFFF for a 16-bit counter.
- R10: A kick while disabled changes neither the count nor the timeout flag.
- R11: With HARD_TOP set, writes leave both selectors at 0xF.
- R12: With ALWAYS_ON set, the watchdog runs and accepts kicks whatever the enable input is, and writes to the initial selector are ignored.
- R13: With DUAL_TOP cleared, the initial selector reads as zero and cannot be written, and the first load uses the normal selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Control word write data |
| rdData | output | 32 | Control word read data |
| enIn | input | 1 | Watchdog enable |
| kick | input | 1 | Restart strobe |
| timeout | output | 1 | Sticky timeout flag |
| count | output | CNT_WIDTH | Current counter value |

## Verification
The hardest cases to reach from the ports are the ones where a selector is changed while the counter is already running. The test must show that the running count does not move, and that only the correct selector is used at the next restart. The bench first enables the watchdog with a short initial period. It then rewrites the normal selector in the middle of a countdown and checks that the count still drops by exactly one. Next it rewrites the initial selector and kicks, then checks that the value loaded comes from the normal selector. The bench uses a small period base, so full timeouts finish in a few cycles while selectors 14 and 15 still reach the clipping limit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int SEL_W   = 4;
  localparam int NUM_SEL = 1 << SEL_W;
  localparam int REG_W   = 32;
  localparam logic [SEL_W-1:0] SEL_RST = 4'hF;

  typedef struct packed {
    logic load;     // reload the counter this clock
    logic useInit;  // reload uses the initial selector
    logic dec;      // count down this clock
    logic setFlag;  // raise the timeout flag
    logic clrFlag;  // clear the timeout flag
  } wdogStrobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter bit HARD_TOP  = 1'b0,
  parameter bit ALWAYS_ON = 1'b0,
  parameter bit DUAL_TOP  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             enIn,
  input  logic             kick,
  input  logic             cntZero,
  output logic [SEL_W-1:0] topSel,
  output logic [SEL_W-1:0] initSel,
  output logic [REG_W-1:0] rdData,
  output wdogStrobes_t     strobes
);
  localparam bit TOP_WRITABLE  = !HARD_TOP;
  localparam bit INIT_WRITABLE = !HARD_TOP && !ALWAYS_ON;

  logic enEff;
  logic wasEn;
  logic enRise;
  logic unusedHi;

  assign unusedHi = ^wrData[REG_W-1:2*SEL_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topSel <= SEL_RST;
    end else if (wrEn && TOP_WRITABLE) begin
      topSel <= wrData[SEL_W-1:0];
    end
  end

  generate
    if (DUAL_TOP) begin : g_initSel
      always_ff @(posedge clk) begin
        if (!rstN) begin
          initSel <= SEL_RST;
        end else if (wrEn && INIT_WRITABLE) begin
          initSel <= wrData[2*SEL_W-1:SEL_W];
        end
      end
    end else begin : g_noInitSel
      assign initSel = '0;
    end
  endgenerate

  assign rdData = {{(REG_W-2*SEL_W){1'b0}}, initSel, topSel};

  assign enEff = ALWAYS_ON ? 1'b1 : enIn;

  always_ff @(posedge clk) begin
    if (!rstN) wasEn <= 1'b0;
    else       wasEn <= enEff;
  end

  assign enRise = enEff && !wasEn;

  always_comb begin
    strobes.load    = enRise || (enEff && kick);
    strobes.useInit = enRise && DUAL_TOP;
    strobes.dec     = enEff && !strobes.load && !cntZero;
    strobes.setFlag = enEff && !strobes.load && cntZero;
    strobes.clrFlag = enEff && kick;
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_WIDTH        = 32,
  parameter int PERIOD_BASE_LOG2 = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wdogStrobes_t         strobes,
  input  logic [SEL_W-1:0]     topSel,
  input  logic [SEL_W-1:0]     initSel,
  output logic [CNT_WIDTH-1:0] count,
  output logic                 timeout,
  output logic                 cntZero
);
  logic [CNT_WIDTH-1:0] loadTable [NUM_SEL];
  logic [SEL_W-1:0]     pickSel;

  // One reload value per selector code, with the exponent clipped to the counter width
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_period
    localparam int RAW_EXP = PERIOD_BASE_LOG2 + g;
    localparam int USE_EXP = (RAW_EXP > CNT_WIDTH) ? CNT_WIDTH : RAW_EXP;
    localparam logic [63:0] FULL = (64'd1 << USE_EXP) - 64'd1;
    assign loadTable[g] = FULL[CNT_WIDTH-1:0];
  end

  assign pickSel = strobes.useInit ? initSel : topSel;
  assign cntZero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.load) begin
      count <= loadTable[pickSel];
    end else if (strobes.dec) begin
      count <= count - CNT_WIDTH'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeout <= 1'b0;
    end else if (strobes.clrFlag) begin
      timeout <= 1'b0;
    end else if (strobes.setFlag) begin
      timeout <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_dualperiod.sv
module wdog_dualperiod
  import wdog_pkg::*;
#(
  parameter int CNT_WIDTH        = 32,
  parameter int PERIOD_BASE_LOG2 = 16,
  parameter bit HARD_TOP         = 1'b0,
  parameter bit ALWAYS_ON        = 1'b0,
  parameter bit DUAL_TOP         = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  input  logic                 enIn,
  input  logic                 kick,
  output logic                 timeout,
  output logic [CNT_WIDTH-1:0] count
);
  wdogStrobes_t     strobes;
  logic [SEL_W-1:0] topSel;
  logic [SEL_W-1:0] initSel;
  logic             cntZero;

  wdog_ctrl #(
    .HARD_TOP (HARD_TOP),
    .ALWAYS_ON(ALWAYS_ON),
    .DUAL_TOP (DUAL_TOP)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .enIn   (enIn),
    .kick   (kick),
    .cntZero(cntZero),
    .topSel (topSel),
    .initSel(initSel),
    .rdData (rdData),
    .strobes(strobes)
  );

  wdog_datapath #(
    .CNT_WIDTH       (CNT_WIDTH),
    .PERIOD_BASE_LOG2(PERIOD_BASE_LOG2)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .topSel (topSel),
    .initSel(initSel),
    .count  (count),
    .timeout(timeout),
    .cntZero(cntZero)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_WIDTH = 32,
  parameter bit HARD_TOP  = 1'b0,
  parameter bit ALWAYS_ON = 1'b0
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [31:0]          rdData,
  input logic                 enIn,
  input logic                 kick,
  input logic                 timeout,
  input logic [CNT_WIDTH-1:0] count
);
  logic enEff;
  logic prevEn;

  assign enEff = ALWAYS_ON ? 1'b1 : enIn;

  always_ff @(posedge clk) begin
    if (!rstN) prevEn <= 1'b0;
    else       prevEn <= enEff;
  end

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:8] == 24'd0);

  p_kick_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enEff && kick) |=> !timeout);

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enEff && prevEn && !kick && count != '0) |=> (count == $past(count) - CNT_WIDTH'(1)));

  p_expire_sets_r6: assert property (@(posedge clk) disable iff (!rstN)
    (enEff && prevEn && !kick && count == '0) |=> timeout);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (timeout && !(enEff && kick)) |=> timeout);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enEff |=> ($stable(count) && $stable(timeout)));

  p_fixed_sel_r11: assert property (@(posedge clk) disable iff (!rstN)
    (HARD_TOP && wrEn) |=> $stable(rdData[7:0]));
endmodule

bind wdog_dualperiod wdog_checker #(
  .CNT_WIDTH(CNT_WIDTH),
  .HARD_TOP (HARD_TOP),
  .ALWAYS_ON(ALWAYS_ON)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdData (rdData),
  .enIn   (enIn),
  .kick   (kick),
  .timeout(timeout),
  .count  (count)
);

// File: tb/tb_wdog_dualperiod.sv
module tb_wdog_dualperiod;
  localparam int W = 16;
  localparam int BASE = 2;
  // {sel[3:0], waitCycles[7:0], expCount[15:0], expTimeout}
  localparam logic [28:0] VEC [9] = '{
    {4'd0,  8'd0,  16'd3,     1'b0},
    {4'd0,  8'd3,  16'd0,     1'b0},
    {4'd0,  8'd4,  16'd0,     1'b1},
    {4'd0,  8'd6,  16'd0,     1'b1},
    {4'd1,  8'd2,  16'd5,     1'b0},
    {4'd3,  8'd10, 16'd21,    1'b0},
    {4'd13, 8'd5,  16'd32762, 1'b0},
    {4'd14, 8'd0,  16'd65535, 1'b0},
    {4'd15, 8'd1,  16'd65534, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic enIn = 1'b0;
  logic kick = 1'b0;
  logic [31:0] rdData, rdHc, rdAo, rdSd;
  logic toMain, toHc, toAo, toSd;
  logic [W-1:0] cntMain, cntHc, cntAo, cntSd;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_dualperiod #(.CNT_WIDTH(W), .PERIOD_BASE_LOG2(BASE)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .enIn(enIn), .kick(kick), .timeout(toMain), .count(cntMain));
  wdog_dualperiod #(.CNT_WIDTH(W), .PERIOD_BASE_LOG2(BASE), .HARD_TOP(1'b1)) dutHc (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdHc),
    .enIn(enIn), .kick(kick), .timeout(toHc), .count(cntHc));
  wdog_dualperiod #(.CNT_WIDTH(W), .PERIOD_BASE_LOG2(BASE), .ALWAYS_ON(1'b1)) dutAo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdAo),
    .enIn(enIn), .kick(kick), .timeout(toAo), .count(cntAo));
  wdog_dualperiod #(.CNT_WIDTH(W), .PERIOD_BASE_LOG2(BASE), .DUAL_TOP(1'b0)) dutSd (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdSd),
    .enIn(enIn), .kick(kick), .timeout(toSd), .count(cntSd));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [31:0] d);
    wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic doKick();
    kick = 1'b1;
    tick();
    kick = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    chk("R1 word", rdData, 32'h0000_00FF);
    chk("R1 count", 32'(cntMain), 32'd0);
    chk("R1 flag", 32'(toMain), 32'd0);
    tick();
    chk("R1 idle count", 32'(cntMain), 32'd0);

    writeWord(32'hFFFF_FF5A);
    chk("R2 upper bits", rdData, 32'h0000_005A);

    writeWord(32'h0000_0010);        // initial sel 1 (P=8), normal sel 0 (P=4)
    enIn = 1'b1;
    tick();
    chk("R3 initial load", 32'(cntMain), 32'd7);
    tick();
    chk("R5 decrement", 32'(cntMain), 32'd6);

    enIn = 1'b0;
    tick();
    chk("R5 hold disabled", 32'(cntMain), 32'd6);
    doKick();
    chk("R10 kick disabled count", 32'(cntMain), 32'd6);
    chk("R10 kick disabled flag", 32'(toMain), 32'd0);

    enIn = 1'b1;
    tick();
    chk("R3 reload on re-enable", 32'(cntMain), 32'd7);
    repeat (7) tick();
    chk("R6 at zero count", 32'(cntMain), 32'd0);
    chk("R6 not yet", 32'(toMain), 32'd0);
    tick();
    chk("R6 flag rises", 32'(toMain), 32'd1);
    repeat (3) tick();
    chk("R6 sticky", 32'(toMain), 32'd1);

    doKick();
    chk("R4 kick load", 32'(cntMain), 32'd3);
    chk("R4 kick clears", 32'(toMain), 32'd0);
    writeWord(32'h0000_0013);
    chk("R7 running count kept", 32'(cntMain), 32'd2);
    doKick();
    chk("R7 new period at kick", 32'(cntMain), 32'd31);
    writeWord(32'h0000_0023);
    doKick();
    chk("R8 initial sel ignored", 32'(cntMain), 32'd31);

    foreach (VEC[k]) begin
      writeWord({28'd0, VEC[k][28:25]});
      doKick();
      repeat (int'(VEC[k][24:17])) tick();
      chk("R4/R9 table count", 32'(cntMain), 32'(VEC[k][16:1]));
      chk("R6 table flag", 32'(toMain), 32'(VEC[k][0]));
    end

    enIn = 1'b0;
    rstN = 1'b0;
    repeat (2) tick();
    rstN = 1'b1;
    writeWord(32'h0000_0055);
    chk("R11 fixed selectors", rdHc, 32'h0000_00FF);
    chk("R12 initial write ignored", rdAo, 32'h0000_00F5);
    chk("R13 initial reads zero", rdSd, 32'h0000_0005);
    doKick();
    chk("R12 kick without enable", 32'(cntAo), 32'd127);
    enIn = 1'b1;
    tick();
    chk("R13 first load uses normal sel", 32'(cntSd), 32'd127);
    chk("R9 clipped hard-coded load", 32'(cntHc), 32'd65535);

    finishRun();
  end
endmodule